// File: doc/BRIEF.md
# ROM Banking Control Register

This block holds the banking state for a small 8-bit processor system. Software changes that state by writing one byte to a single I/O port. The latched fields feed a combinational memory decoder that produces the ROM and RAM chip selects:

- a three-bit page number picks one of eight 4 KB ROM pages shown in a fixed window near the top of memory;
- a boot overlay flag makes ROM answer reads at every address, so the processor can fetch code from address zero after reset;
- an enable flag maps the ROM window in or out.

A read of the same I/O port returns a status byte. That byte holds the page, overlay and enable fields, plus the setting of a three-bit option switch. One more bit of the register lights a user LED.

Two strap inputs choose the reset value of the overlay and enable flags. A board can therefore boot from ROM or start with ROM fully unmapped, without any change to the logic. The page and the LED always clear on reset. Reset is synchronous and active high.

Top module: `bank_ctl_top`

## Requirements
- R1: While `rst` is high at a clock edge, the page becomes 0 and the LED turns off. The overlay flag loads `strap_boot` and the enable flag loads `strap_rom_en`.
- R2: A write takes effect at the clock edge where `io_wr` is high and `io_addr` equals 0x02 (I/O base 0x00 plus offset 0x02). A write to any other I/O address leaves every field unchanged.
- R3: Write data bits 2:0 set the page. `rom_page` shows the page from the edge that latches the write.
- R4: While the overlay flag (write data bit 3) is 1, every memory read asserts `rom_cs`. A memory write without a read asserts `ram_cs`.
- R5: The overlay flag takes priority over the enable flag. With the overlay on and the enable flag 0, reads still select ROM.
- R6: With the overlay off and the enable flag (write data bit 4) at 1, an access with `mem_addr[15:12]` = 0xF selects ROM and any other access selects RAM. With the enable flag at 0, every access selects RAM. Changing the enable flag leaves the page unchanged.
- R7: Write data bits 6:5 are ignored. The outputs and the status byte are the same whatever those bits hold.
- R8: Write data bit 7 drives `user_led`, where 1 means on.
- R9: `io_rdata` is registered. One cycle after a cycle with `io_addr` = 0x02, it holds {`opt_sw`, enable, overlay, page[2:0]}. After a cycle with any other `io_addr`, it holds 0x00.
- R10: `rom_cs` and `ram_cs` are never high together. Both stay low when neither `mem_rd` nor `mem_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe |
| strap_boot | input | 1 | Reset value of the overlay flag |
| strap_rom_en | input | 1 | Reset value of the ROM enable flag |
| mem_addr | input | 16 | Memory address |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| opt_sw | input | 3 | Option switch setting |
| rom_cs | output | 1 | ROM chip select |
| ram_cs | output | 1 | RAM chip select |
| rom_page | output | 3 | Upper ROM address lines (page) |
| user_led | output | 1 | User LED, 1 = on |
| io_rdata | output | 8 | Registered status byte |

## Verification
The two functions that meet in one cycle are a register write and a memory access that depends on the field being written. The bench produces this by asserting `io_wr` with overlay or enable changes while `mem_rd` or `mem_wr` is active, and while `io_addr` selects the status port. Two results are judged against a cycle-by-cycle model in the bench. The chip selects must still follow the old field values in that cycle and switch only after the edge. The status byte must report the state from before the write.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int PAGE_W = 3;
  localparam int DATA_W = 8;
  localparam int SW_W   = DATA_W - PAGE_W - 2;

  localparam int BOOT_BIT = PAGE_W;
  localparam int EN_BIT   = PAGE_W + 1;
  localparam int LED_BIT  = DATA_W - 1;

  typedef struct packed {
    logic              led;
    logic              en;
    logic              boot;
    logic [PAGE_W-1:0] page;
  } bank_ctl_t;
endpackage

// File: rtl/bank_ctl_reg.sv
module bank_ctl_reg
  import bank_pkg::*;
#(
  parameter int          IO_W     = 8,
  parameter logic [7:0]  IO_BASE  = 8'h00,
  parameter logic [7:0]  REG_OFS  = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IO_W-1:0]   io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_wr,
  input  logic              strap_boot,
  input  logic              strap_rom_en,
  output bank_ctl_t         ctl,
  output logic              sel
);
  localparam logic [IO_W-1:0] REG_ADDR = IO_W'(IO_BASE + REG_OFS);

  logic wr_hit;

  always_comb begin
    sel    = (io_addr == REG_ADDR);
    wr_hit = sel && io_wr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl.page <= '0;
      ctl.boot <= strap_boot;
      ctl.en   <= strap_rom_en;
      ctl.led  <= 1'b0;
    end else if (wr_hit) begin
      ctl.page <= io_wdata[PAGE_W-1:0];
      ctl.boot <= io_wdata[BOOT_BIT];
      ctl.en   <= io_wdata[EN_BIT];
      ctl.led  <= io_wdata[LED_BIT];
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (ctl.page == '0) && !ctl.led); // R1
  AST_RESET_STRAPS: assert property (@(posedge clk)
    rst |=> (ctl.boot == $past(strap_boot)) && (ctl.en == $past(strap_rom_en))); // R1
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (ctl.page == $past(io_wdata[PAGE_W-1:0])) && (ctl.led == $past(io_wdata[LED_BIT]))); // R2
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && (io_addr == REG_ADDR)) |=> $stable(ctl)); // R2
endmodule

// File: rtl/bank_map.sv
module bank_map
  import bank_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                WIN_W    = 12,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'hF000
) (
  input  logic              clk,
  input  logic              rst,
  input  bank_ctl_t         ctl,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  output logic              rom_cs,
  output logic              ram_cs,
  output logic [PAGE_W-1:0] rom_page
);
  localparam int TAG_W = ADDR_W - WIN_W;
  localparam logic [TAG_W-1:0] WIN_TAG = ROM_BASE[ADDR_W-1:WIN_W];

  logic access;
  logic in_win;
  logic rom_claim;

  always_comb begin
    access = mem_rd || mem_wr;
    in_win = (mem_addr[ADDR_W-1:WIN_W] == WIN_TAG);
    if (ctl.boot)
      rom_claim = mem_rd;
    else
      rom_claim = ctl.en && in_win;
    rom_cs   = access && rom_claim;
    ram_cs   = access && !rom_claim;
    rom_page = ctl.page;
  end

  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rom_cs && ram_cs) && (rom_cs || ram_cs || !(mem_rd || mem_wr))); // R10
  AST_OVERLAY_READ: assert property (@(posedge clk) disable iff (rst)
    (ctl.boot && mem_rd) |-> rom_cs); // R4
  AST_OVERLAY_WRITE: assert property (@(posedge clk) disable iff (rst)
    (ctl.boot && mem_wr && !mem_rd) |-> ram_cs); // R4
  AST_DISABLED_RAM: assert property (@(posedge clk) disable iff (rst)
    (!ctl.boot && !ctl.en && (mem_rd || mem_wr)) |-> ram_cs); // R6
endmodule

// File: rtl/bank_status.sv
module bank_status
  import bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  bank_ctl_t         ctl,
  input  logic              sel,
  input  logic [SW_W-1:0]   opt_sw,
  output logic [DATA_W-1:0] io_rdata
);
  always_ff @(posedge clk) begin
    if (rst)
      io_rdata <= '0;
    else if (sel)
      io_rdata <= {opt_sw, ctl.en, ctl.boot, ctl.page};
    else
      io_rdata <= '0;
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (io_rdata == '0)); // R9
  AST_RD_SWITCH: assert property (@(posedge clk) disable iff (rst)
    sel |=> (io_rdata[DATA_W-1:DATA_W-SW_W] == $past(opt_sw))); // R9
endmodule

// File: rtl/bank_ctl_top.sv
module bank_ctl_top
  import bank_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                WIN_W    = 12,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'hF000,
  parameter logic [7:0]        IO_BASE  = 8'h00,
  parameter logic [7:0]        REG_OFS  = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              strap_boot,
  input  logic              strap_rom_en,
  input  logic [15:0]       mem_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic [2:0]        opt_sw,
  output logic              rom_cs,
  output logic              ram_cs,
  output logic [2:0]        rom_page,
  output logic              user_led,
  output logic [7:0]        io_rdata
);
  bank_ctl_t ctl;
  logic      sel;

  bank_ctl_reg #(
    .IO_W(8), .IO_BASE(IO_BASE), .REG_OFS(REG_OFS)
  ) u_reg (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .strap_boot(strap_boot), .strap_rom_en(strap_rom_en),
    .ctl(ctl), .sel(sel)
  );

  bank_map #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .ROM_BASE(ROM_BASE)
  ) u_map (
    .clk(clk), .rst(rst), .ctl(ctl), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr),
    .rom_cs(rom_cs), .ram_cs(ram_cs), .rom_page(rom_page)
  );

  bank_status u_stat (
    .clk(clk), .rst(rst), .ctl(ctl), .sel(sel),
    .opt_sw(opt_sw), .io_rdata(io_rdata)
  );

  assign user_led = ctl.led;

  AST_LED_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (io_wr && sel) |=> (user_led == $past(io_wdata[7]))); // R8
endmodule

// File: tb/sim_bank_ctl_top.sv
`timescale 1ns/1ps
module sim_bank_ctl_top;
  logic clk = 0, rst = 1;
  logic [7:0] io_addr = 0, io_wdata = 0;
  logic io_wr = 0, strap_boot = 1, strap_rom_en = 1;
  logic [15:0] mem_addr = 0;
  logic mem_rd = 0, mem_wr = 0;
  logic [2:0] opt_sw = 3'b101;
  logic rom_cs, ram_cs, user_led;
  logic [2:0] rom_page;
  logic [7:0] io_rdata;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit mvalid = 0;
  int m_page = 0, m_boot = 0, m_en = 0, m_led = 0, m_rd = 0;

  always #2.5 clk = ~clk;

  bank_ctl_top u0 (.*);

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc();
    int claim, acc;
    #1;
    if (mvalid) begin
      acc = (mem_rd || mem_wr) ? 1 : 0;
      if (m_boot != 0) claim = mem_rd ? 1 : 0;
      else claim = (m_en != 0 && mem_addr[15:12] == 4'hF) ? 1 : 0;
      chk("rom_cs", int'(rom_cs), acc & claim);
      chk("ram_cs", int'(ram_cs), acc & (claim ^ 1));
      chk("rom_page", int'(rom_page), m_page);
      chk("user_led", int'(user_led), m_led);
    end
    @(posedge clk);
    if (rst) begin
      m_page = 0; m_led = 0; m_rd = 0;
      m_boot = int'(strap_boot); m_en = int'(strap_rom_en);
      mvalid = 1;
    end else begin
      m_rd = (io_addr == 8'h02) ? ((int'(opt_sw) << 5) | (m_en << 4) | (m_boot << 3) | m_page) : 0;
      if (io_wr && io_addr == 8'h02) begin
        m_page = io_wdata[2:0]; m_boot = io_wdata[3];
        m_en = io_wdata[4]; m_led = io_wdata[7];
      end
    end
    @(negedge clk);
    if (mvalid) chk("io_rdata", int'(io_rdata), m_rd);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1; cyc(); io_wr = 0; io_addr = 8'h00;
  endtask

  task automatic mem(logic [15:0] a, bit r, bit w);
    mem_addr = a; mem_rd = r; mem_wr = w; cyc(); mem_rd = 0; mem_wr = 0;
  endtask

  task automatic rdstat();
    io_addr = 8'h02; cyc(); io_addr = 8'h00; cyc();
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    tag = "R1"; cyc(); cyc(); rst = 0;
    cyc(); rdstat();
    tag = "R4"; mem(16'h0000, 1, 0); mem(16'h1234, 1, 0); mem(16'h8000, 1, 0); mem(16'h0000, 0, 1);
    tag = "R10"; mem(16'hF000, 0, 0); mem(16'h0100, 0, 0);
    tag = "R2"; wr(8'h03, 8'h00); mem(16'h4000, 1, 0); wr(8'h12, 8'h00); rdstat();
    // write turning overlay off while a read is in the same cycle
    mem_addr = 16'h2000; mem_rd = 1; wr(8'h02, 8'h13); mem(16'h2000, 1, 0);
    tag = "R6"; mem(16'hF000, 1, 0); mem(16'hFFFF, 1, 0); mem(16'hEFFF, 1, 0); mem(16'hF010, 0, 1);
    tag = "R3";
    for (int p = 0; p < 8; p++) begin
      wr(8'h02, 8'h10 | 8'(p)); mem(16'hF123, 1, 0); rdstat();
    end
    tag = "R5"; wr(8'h02, 8'h0A); mem(16'h0000, 1, 0); mem(16'hF000, 1, 0); mem(16'h7777, 0, 1); rdstat();
    tag = "R7"; wr(8'h02, 8'h75); rdstat(); mem(16'hF001, 1, 0); wr(8'h02, 8'h15); rdstat();
    tag = "R8"; wr(8'h02, 8'h95); cyc(); wr(8'h02, 8'h15); cyc();
    tag = "R6"; wr(8'h02, 8'h05); mem(16'hF000, 1, 0); mem(16'hF800, 0, 1); rdstat();
    wr(8'h02, 8'h15); mem(16'hF000, 1, 0);
    tag = "R9"; opt_sw = 3'b010; io_addr = 8'h02; io_wr = 1; io_wdata = 8'h1B; cyc(); io_wr = 0; cyc(); io_addr = 8'h01; cyc(); cyc();
    tag = "R1"; strap_boot = 0; strap_rom_en = 0; wr(8'h02, 8'h9F); rst = 1; cyc(); rst = 0;
    cyc(); rdstat(); mem(16'h0000, 1, 0); mem(16'hF000, 1, 0);
    tag = "R10"; mem(16'hF000, 1, 1); mem(16'h3000, 1, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule